// File: doc/BRIEF.md
# Parallel Port FIFO and Register Decoder with Test Mode

This block holds the byte FIFO and the host-visible register decode of an extended-capability parallel port. A host bus with a two-bit offset reaches three locations: a shared data offset, a second configuration offset, and a control register. A three-bit mode field in the control register decides what the shared data offset means. It can be the transfer FIFO for the extended-capability protocol, a test FIFO the host can fill and drain itself, or a pair of fixed read-only configuration words.

A plain push/pop byte port stands in for the peripheral side of the link. In the forward direction (direction bit 0), the host fills the FIFO and the peripheral port drains it. In the reverse direction (direction bit 1), the peripheral port fills it and host reads drain it. Full and empty flags and a service-interrupt level come out as ports. The service interrupt follows a free-space threshold when sending and a filled-space threshold when receiving.

Test mode never stalls. A write to a full FIFO is dropped. A read from an empty FIFO repeats the byte that was last read. Any write to the control register that changes the mode empties the FIFO.

Top module: `pport_xfifo`

## Requirements
- R1: The control register sits at offset 2 and is reachable in every mode. A write stores bits 7:5 as the mode and bit 0 as the direction bit. A read returns {mode[2:0], 2'b00, full, empty, direction}, so it reads 8'h02 after reset.
- R2: Bytes leave the FIFO from its head in the order they were written, with either value of the direction bit. For example, 44h, 33h, 22h come back as 44h, 33h, 22h.
- R3: In test mode (mode 3'b110), a host write to offset 0 while the FIFO holds 16 bytes is discarded. The stored bytes and the full flag stay unchanged.
- R4: In test mode, a host read of offset 0 while the FIFO is empty returns the byte most recently read (00h if none since reset) and leaves the pointers unchanged. A later write and read still work normally.
- R5: fifo_empty is 1 exactly when the FIFO holds 0 bytes, and fifo_full is 1 exactly when it holds 16 bytes. This also holds after dropped writes and underrun reads. The two flags are never 1 together.
- R6: In configuration mode (mode 3'b111), offset 0 reads 8'h10, and host writes to it have no effect.
- R7: In configuration mode, offset 1 reads {1'b0, strap_cfg[6:0]}, so bit 7 is always 0. Host writes to offset 1 have no effect.
- R8: In transfer mode (mode 3'b011) with direction 0, host writes to offset 0 enter the FIFO, per_pop drains it, per_push is ignored, and host reads of offset 0 return 00h without removing a byte. With direction 1, per_push fills the FIFO, host reads of offset 0 return and remove the head byte, and host writes to offset 0 are ignored.
- R9: In transfer or test mode, service_intr is 1 with direction 0 when at least 8 entries are free, and 1 with direction 1 when at least 8 entries are filled. In any other mode it is 0. It changes on the same clock edge as the FIFO occupancy.
- R10: Reset, or a control-register write whose mode differs from the current mode, leaves the FIFO empty. A write that keeps the mode and changes only the direction keeps the FIFO contents.
- R11: In modes other than transfer, test and configuration, offsets 0 and 1 read 00h, host writes to offset 0 are ignored, and both peripheral strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_rd | input | 1 | Host read strobe; a FIFO read removes a byte on the edge that ends the cycle |
| host_addr | input | 2 | Offset: 0 data/config A, 1 config B, 2 control |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for the current offset, combinational |
| strap_cfg | input | 7 | Fixed value shown in config B bits 6:0 |
| per_push | input | 1 | Peripheral-side push strobe |
| per_push_data | input | 8 | Byte pushed by the peripheral side |
| per_pop | input | 1 | Peripheral-side pop strobe |
| per_pop_data | output | 8 | Current head byte offered to the peripheral side |
| fifo_full | output | 1 | FIFO holds 16 bytes |
| fifo_empty | output | 1 | FIFO holds no bytes |
| service_intr | output | 1 | Threshold service request level |

## Verification
A wrong read or write pointer shows up on the next host read or peripheral pop as a byte out of order or a repeated byte. The bench compares each drained byte against the written sequence. A miscounted occupancy shows up within one cycle on fifo_full, fifo_empty, or service_intr at a threshold crossing, so the bench walks the count across both thresholds and both ends. A lost mode or direction bit shows immediately in the control readback, or as a FIFO that was not flushed on the next read.

// File: rtl/pport_pkg.sv
package pport_pkg;
    localparam int BYTE_W = 8;

    typedef logic [2:0] mode_t;

    localparam mode_t MODE_XFER = 3'b011;
    localparam mode_t MODE_TEST = 3'b110;
    localparam mode_t MODE_CFG  = 3'b111;

    localparam logic [1:0] OFS_DATA = 2'd0;
    localparam logic [1:0] OFS_CFGB = 2'd1;
    localparam logic [1:0] OFS_CTRL = 2'd2;

    localparam logic [BYTE_W-1:0] CFGA_WORD = 8'h10;
endpackage

// File: rtl/pport_store.sv
module pport_store #(
    parameter int DEPTH  = 16,
    parameter int WIDTH  = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_byte,
    input  logic [PTR_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_byte
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            cells[wr_idx] <= wr_byte;
        end
    end

    assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/pport_thresh.sv
module pport_thresh
    import pport_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WR_THRESH = 8,
    parameter int RD_THRESH = 8,
    parameter int CNT_W     = $clog2(DEPTH) + 1
) (
    input  mode_t            mode,
    input  logic             dir,
    input  logic [CNT_W-1:0] fill,
    output logic             svc
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] WR_C    = CNT_W'(WR_THRESH);
    localparam logic [CNT_W-1:0] RD_C    = CNT_W'(RD_THRESH);

    logic fifo_mode;
    logic [CNT_W-1:0] room;

    always_comb begin
        fifo_mode = (mode == MODE_XFER) || (mode == MODE_TEST);
        room      = DEPTH_C - fill;
        if (!fifo_mode) begin
            svc = 1'b0;
        end else if (dir) begin
            svc = (fill >= RD_C);
        end else begin
            svc = (room >= WR_C);
        end
    end
endmodule

// File: rtl/pport_readback.sv
module pport_readback
    import pport_pkg::*;
(
    input  logic [1:0]        addr,
    input  mode_t             mode,
    input  logic              dir,
    input  logic              full,
    input  logic              empty,
    input  logic [BYTE_W-1:0] head,
    input  logic [BYTE_W-1:0] last,
    input  logic [6:0]        strap,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            OFS_CTRL: rdata = {mode, 2'b00, full, empty, dir};
            OFS_CFGB: rdata = (mode == MODE_CFG) ? {1'b0, strap} : '0;
            OFS_DATA: begin
                if (mode == MODE_CFG) begin
                    rdata = CFGA_WORD;
                end else if (mode == MODE_TEST) begin
                    rdata = empty ? last : head;
                end else if (mode == MODE_XFER && dir && !empty) begin
                    rdata = head;
                end
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_xfifo.sv
module pport_xfifo
    import pport_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int WR_THRESH = 8,
    parameter int RD_THRESH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic [1:0]  host_addr,
    input  logic [7:0]  host_wdata,
    output logic [7:0]  host_rdata,
    input  logic [6:0]  strap_cfg,
    input  logic        per_push,
    input  logic [7:0]  per_push_data,
    input  logic        per_pop,
    output logic [7:0]  per_pop_data,
    output logic        fifo_full,
    output logic        fifo_empty,
    output logic        service_intr
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_IX = PTR_W'(DEPTH - 1);

    typedef struct packed {
        mode_t             mode;
        logic              dir;
        logic [PTR_W-1:0]  wptr;
        logic [PTR_W-1:0]  rptr;
        logic [CNT_W-1:0]  count;
        logic [BYTE_W-1:0] last;
    } state_t;

    state_t st_d, st_q;

    logic              push_ok, pop_ok;
    logic [BYTE_W-1:0] push_byte;
    logic [BYTE_W-1:0] head;
    mode_t             cur_mode;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IX) ? '0 : p + 1'b1;
    endfunction

    assign fifo_full    = (st_q.count == DEPTH_C);
    assign fifo_empty   = (st_q.count == '0);
    assign per_pop_data = head;
    assign cur_mode     = st_q.mode;

    always_comb begin
        logic is_xfer, is_test, at_data, push_req, pop_host, pop_req;
        st_d     = st_q;
        is_xfer  = (st_q.mode == MODE_XFER);
        is_test  = (st_q.mode == MODE_TEST);
        at_data  = (host_addr == OFS_DATA);

        push_req = (host_wr && at_data && (is_test || (is_xfer && !st_q.dir)))
                 || (per_push && is_xfer && st_q.dir);
        push_byte = (is_xfer && st_q.dir) ? per_push_data : host_wdata;
        pop_host = host_rd && at_data && (is_test || (is_xfer && st_q.dir));
        pop_req  = pop_host || (per_pop && is_xfer && !st_q.dir);

        push_ok  = push_req && !fifo_full;
        pop_ok   = pop_req && !fifo_empty;

        if (push_ok) begin
            st_d.wptr = bump(st_q.wptr);
        end
        if (pop_ok) begin
            st_d.rptr = bump(st_q.rptr);
            if (pop_host) begin
                st_d.last = head;
            end
        end
        st_d.count = st_q.count + CNT_W'(push_ok) - CNT_W'(pop_ok);

        if (host_wr && host_addr == OFS_CTRL) begin
            st_d.mode = host_wdata[7:5];
            st_d.dir  = host_wdata[0];
            if (host_wdata[7:5] != st_q.mode) begin
                st_d.wptr  = '0;
                st_d.rptr  = '0;
                st_d.count = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    pport_store #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_store (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_idx  (st_q.wptr),
        .wr_byte (push_byte),
        .rd_idx  (st_q.rptr),
        .rd_byte (head)
    );

    pport_thresh #(.DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .RD_THRESH(RD_THRESH)) u_thresh (
        .mode (st_q.mode),
        .dir  (st_q.dir),
        .fill (st_q.count),
        .svc  (service_intr)
    );

    pport_readback u_readback (
        .addr  (host_addr),
        .mode  (st_q.mode),
        .dir   (st_q.dir),
        .full  (fifo_full),
        .empty (fifo_empty),
        .head  (head),
        .last  (st_q.last),
        .strap (strap_cfg),
        .rdata (host_rdata)
    );
endmodule

// File: rtl/pport_xfifo_chk.sv
module pport_xfifo_chk
    import pport_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic       host_rd,
    input logic [1:0] host_addr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input mode_t      mode,
    input logic       fifo_full,
    input logic       fifo_empty
);
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_full && fifo_empty));

    assert_full_write_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TEST && fifo_full && host_wr && !host_rd && host_addr == OFS_DATA)
        |=> fifo_full);

    assert_underrun_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TEST && fifo_empty && host_rd && !host_wr && host_addr == OFS_DATA)
        |=> fifo_empty);

    assert_cfga_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CFG && host_addr == OFS_DATA) |-> host_rdata == 8'h10);

    assert_cfgb_msb_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CFG && host_addr == OFS_CFGB) |-> !host_rdata[7]);

    assert_mode_change_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == OFS_CTRL && host_wdata[7:5] != mode) |=> fifo_empty);
endmodule

bind pport_xfifo pport_xfifo_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .mode       (cur_mode),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty)
);

// File: tb/pport_xfifo_bench.sv
module pport_xfifo_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0] host_addr = 2'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic [6:0] strap_cfg = 7'h5B;
    logic       per_push = 1'b0, per_pop = 1'b0;
    logic [7:0] per_push_data = 8'h00;
    logic [7:0] per_pop_data;
    logic       fifo_full, fifo_empty, service_intr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pport_xfifo u_pport_xfifo (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .strap_cfg(strap_cfg), .per_push(per_push), .per_push_data(per_push_data),
        .per_pop(per_pop), .per_pop_data(per_pop_data), .fifo_full(fifo_full),
        .fifo_empty(fifo_empty), .service_intr(service_intr)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic peer_push(input logic [7:0] d);
        @(negedge clk);
        per_push = 1'b1; per_push_data = d;
        @(negedge clk);
        per_push = 1'b0;
    endtask

    task automatic peer_pop();
        @(negedge clk);
        per_pop = 1'b1;
        @(negedge clk);
        per_pop = 1'b0;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        host_read(2'd2, v);
        check("R1 ctrl after reset", v, 8'h02);
        check("R5 empty after reset", {7'd0, fifo_empty}, 8'h01);
        check("R9 intr off in mode 0", {7'd0, service_intr}, 8'h00);
    endtask

    task automatic t_order();
        logic [7:0] v;
        host_write(2'd2, 8'hC0);
        host_read(2'd2, v);
        check("R1 ctrl readback test mode", v, 8'hC2);
        host_write(2'd0, 8'h44); host_write(2'd0, 8'h33); host_write(2'd0, 8'h22);
        host_read(2'd0, v); check("R2 order dir0 #1", v, 8'h44);
        host_read(2'd0, v); check("R2 order dir0 #2", v, 8'h33);
        host_read(2'd0, v); check("R2 order dir0 #3", v, 8'h22);
        host_write(2'd2, 8'hC1);
        host_write(2'd0, 8'h11); host_write(2'd0, 8'h29);
        host_write(2'd2, 8'hC0);
        check("R10 dir-only change keeps data", {7'd0, fifo_empty}, 8'h00);
        host_write(2'd2, 8'hC1);
        host_read(2'd0, v); check("R2 order dir1 #1", v, 8'h11);
        host_read(2'd0, v); check("R2 order dir1 #2", v, 8'h29);
    endtask

    task automatic t_full_and_underrun();
        logic [7:0] v;
        host_write(2'd2, 8'hC0);
        for (int i = 0; i < 16; i++) host_write(2'd0, 8'(i * 3 + 1));
        check("R5 full at 16", {7'd0, fifo_full}, 8'h01);
        check("R9 no room dir0", {7'd0, service_intr}, 8'h00);
        host_write(2'd0, 8'hEE);
        check("R3 full kept after drop", {7'd0, fifo_full}, 8'h01);
        for (int i = 0; i < 16; i++) begin
            host_read(2'd0, v);
            check("R3 contents unchanged", v, 8'(i * 3 + 1));
        end
        check("R5 empty after drain", {6'd0, fifo_full, fifo_empty}, 8'h01);
        host_read(2'd0, v);
        check("R4 underrun repeats last", v, 8'h2E);
        check("R4 still empty", {7'd0, fifo_empty}, 8'h01);
        host_write(2'd0, 8'h5A);
        host_read(2'd0, v);
        check("R4 pointers intact", v, 8'h5A);
    endtask

    task automatic t_config();
        logic [7:0] v;
        host_write(2'd2, 8'hE0);
        host_read(2'd0, v); check("R6 config A", v, 8'h10);
        host_write(2'd0, 8'h55);
        host_read(2'd0, v); check("R6 config A write ignored", v, 8'h10);
        host_read(2'd1, v); check("R7 config B strap", v, 8'h5B);
        strap_cfg = 7'h7F;
        host_write(2'd1, 8'hFF);
        host_read(2'd1, v); check("R7 config B msb zero", v, 8'h7F);
        check("R9 intr off in config", {7'd0, service_intr}, 8'h00);
    endtask

    task automatic t_transfer();
        logic [7:0] v;
        host_write(2'd2, 8'h60);
        host_write(2'd0, 8'hA1); host_write(2'd0, 8'hB2);
        host_read(2'd0, v);
        check("R8 fwd host read is zero", v, 8'h00);
        check("R8 fwd host read no pop", per_pop_data, 8'hA1);
        peer_push(8'h77);
        peer_pop();
        check("R8 fwd peer pop order", per_pop_data, 8'hB2);
        peer_pop();
        check("R8 fwd peer push ignored", {7'd0, fifo_empty}, 8'h01);
        host_write(2'd2, 8'h61);
        host_write(2'd0, 8'h99);
        check("R8 rev host write ignored", {7'd0, fifo_empty}, 8'h01);
        peer_push(8'hC4); peer_push(8'hD5);
        host_read(2'd0, v); check("R8 rev host read #1", v, 8'hC4);
        host_read(2'd0, v); check("R8 rev host read #2", v, 8'hD5);
        check("R8 rev drained", {7'd0, fifo_empty}, 8'h01);
    endtask

    task automatic t_thresholds();
        logic [7:0] v;
        host_write(2'd2, 8'h60);
        check("R9 fwd empty intr", {7'd0, service_intr}, 8'h01);
        for (int i = 0; i < 8; i++) host_write(2'd0, 8'(i));
        check("R9 fwd 8 free", {7'd0, service_intr}, 8'h01);
        host_write(2'd0, 8'h08);
        check("R9 fwd 7 free", {7'd0, service_intr}, 8'h00);
        host_write(2'd2, 8'hC1);
        check("R10 mode change flush", {7'd0, fifo_empty}, 8'h01);
        for (int i = 0; i < 7; i++) host_write(2'd0, 8'(i));
        check("R9 rev 7 filled", {7'd0, service_intr}, 8'h00);
        host_write(2'd0, 8'h07);
        check("R9 rev 8 filled", {7'd0, service_intr}, 8'h01);
        host_write(2'd2, 8'h00);
        check("R10 flush to mode 0", {6'd0, fifo_empty, service_intr}, 8'h02);
        host_write(2'd0, 8'h3C);
        peer_push(8'h4D);
        check("R11 writes ignored idle mode", {7'd0, fifo_empty}, 8'h01);
        host_read(2'd0, v); check("R11 idle data reads zero", v, 8'h00);
        host_read(2'd1, v); check("R11 idle cfgB reads zero", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_order();
        t_full_and_underrun();
        t_config();
        t_transfer();
        t_thresholds();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule